// File: doc/BRIEF.md
# LVDS Test Observation Selector with Configuration Registers

This block routes one LVDS receiver input of a DAC data interface onto a single test pin, so that edge timing of two neighbouring inputs can be compared on an oscilloscope one after the other. A pair address picks two adjacent signals from the data port B bits, the data port A bits and the LVDS data clock. A select bit decides whether the first signal of the pair appears unchanged or the second appears inverted. The result is driven only while the selector is enabled and the separate test-I/O function is switched off.

The selector's control sits in a small register bank written through a 16-bit command word. The bank also holds the control fields of the output linearization circuit: a gain field, a disable bit and a two-field voltage window. These fields come straight out to the analog side, and every field has a fixed reset value. Reads return the register contents one cycle after the request.

Top module: `tmux_observe`

## Requirements
- R1: After synchronous reset, register 0x07 reads 0x00, 0x08 reads 0x80, 0x18 reads 0x00 and 0x19 reads 0x00. The test output is 0, lin_gain is 0, lin_off is 0, win_hi is 4'b1000 and win_lo is 4'b0000.
- R2: A command is accepted on a clock edge with cfg_valid high. Bit 15 is 1 for a read and 0 for a write, bits 14:8 are the register address and bits 7:0 are the write data. A write takes effect at that edge. Read data appears on cfg_rdata after that edge and holds until the next read.
- R3: Register 0x18 holds the selector enable in bit 6, the 5-bit pair address in bits 5:1 and the select bit in bit 0. Bit 7 is ignored and reads 0. Writing 0x60 enables pair address 16 with select 0.
- R4: With the selector active and select = 0, tst_out equals the first signal of the addressed pair.
- R5: With the selector active and select = 1, tst_out equals the inverse of the second signal of the addressed pair.
- R6: Pair address k for 1 ≤ k ≤ 15 pairs port_b[k-1] (first) with port_b[k] (second). Address 16 pairs port_b[15] with dclk_in.
- R7: Pair address 16+k for 1 ≤ k ≤ 15 pairs port_a[k-1] (first) with port_a[k] (second). This holds only while dual_port = 1. In single-port mode these addresses drive tst_out to 0.
- R8: tst_out is 0 unless register 0x18 bit 6 is 1 and register 0x19 bit 0 (test-I/O enable) is 0. Register 0x19 bits 7:1 read 0.
- R9: Pair address 0 drives tst_out to 0.
- R10: Reads of any address other than 0x07, 0x08, 0x18 and 0x19 return 0x00. Writes to such addresses change no register.
- R11: Register 0x07 holds lin_gain in bits 3:0 and lin_off in bit 4, and its bits 7:5 read 0. Register 0x08 holds win_hi in bits 7:4 and win_lo in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Command word valid |
| cfg_word | input | 16 | Read flag, address, write data |
| cfg_rdata | output | 8 | Registered read data |
| dual_port | input | 1 | 1 = both data ports in use |
| port_a | input | 16 | Port A receiver outputs |
| port_b | input | 16 | Port B receiver outputs |
| dclk_in | input | 1 | LVDS data clock receiver output |
| lin_gain | output | 4 | Linearization gain field |
| lin_off | output | 1 | Linearization disable |
| win_hi | output | 4 | Linearization window maximum |
| win_lo | output | 4 | Linearization window minimum |
| tst_out | output | 1 | Test observation output |

## Verification
A corrupted control register appears at once on tst_out, because the output path from the registers is combinational. An enable or select bit held wrongly shows as a stuck, inverted or wrong-neighbour signal in the same cycle that the input pattern changes. A wrong stored value also shows on cfg_rdata one cycle after a read of that address. The linearization fields are visible on their own ports directly after the writing edge. The random phase changes the inputs and the pair address together, so that a routing error at any address reaches the port within a few commands.

// File: rtl/tmux_pkg.sv
package tmux_pkg;

    localparam int CMD_W  = 16;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int PAIR_W = 5;

    localparam logic [ADDR_W-1:0] A_LIN_GAIN = 7'h07;
    localparam logic [ADDR_W-1:0] A_LIN_WIN  = 7'h08;
    localparam logic [ADDR_W-1:0] A_MUX      = 7'h18;
    localparam logic [ADDR_W-1:0] A_TIO      = 7'h19;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic              en;
        logic [PAIR_W-1:0] pair;
        logic              sel;
    } mux_ctrl_t;

    typedef struct packed {
        logic [3:0] gain;
        logic       off;
        logic [3:0] hi;
        logic [3:0] lo;
    } lin_ctrl_t;

    localparam lin_ctrl_t LIN_RST = '{gain: 4'h0, off: 1'b0, hi: 4'h8, lo: 4'h0};

    function automatic logic [DATA_W-1:0] mux_to_byte(mux_ctrl_t m);
        return {1'b0, m.en, m.pair, m.sel};
    endfunction

    function automatic mux_ctrl_t byte_to_mux(logic [DATA_W-1:0] b);
        mux_ctrl_t m;
        m.en   = b[6];
        m.pair = b[5:1];
        m.sel  = b[0];
        return m;
    endfunction

endpackage

// File: rtl/tmux_regs.sv
module tmux_regs
    import tmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_vld,
    input  cmd_t              cmd,
    output logic [DATA_W-1:0] rdata,
    output mux_ctrl_t         mux_q,
    output logic              tio_q,
    output lin_ctrl_t         lin_q
);

    logic wr;
    assign wr = cmd_vld && !cmd.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            mux_q <= '0;
            tio_q <= 1'b0;
            lin_q <= LIN_RST;
        end else if (wr) begin
            case (cmd.addr)
                A_LIN_GAIN: begin
                    lin_q.gain <= cmd.data[3:0];
                    lin_q.off  <= cmd.data[4];
                end
                A_LIN_WIN: begin
                    lin_q.hi <= cmd.data[7:4];
                    lin_q.lo <= cmd.data[3:0];
                end
                A_MUX:   mux_q <= byte_to_mux(cmd.data);
                A_TIO:   tio_q <= cmd.data[0];
                default: ;
            endcase
        end
    end

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        case (cmd.addr)
            A_LIN_GAIN: rd_mux = {3'b000, lin_q.off, lin_q.gain};
            A_LIN_WIN:  rd_mux = {lin_q.hi, lin_q.lo};
            A_MUX:      rd_mux = mux_to_byte(mux_q);
            A_TIO:      rd_mux = {7'b0, tio_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata <= '0;
        else if (cmd_vld && cmd.rd) rdata <= rd_mux;
    end

    logic known;
    assign known = (cmd.addr == A_LIN_GAIN) || (cmd.addr == A_LIN_WIN) ||
                   (cmd.addr == A_MUX) || (cmd.addr == A_TIO);

    p_unimpl_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd.rd && !known) |=> (rdata == '0));

    p_unimpl_write_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && !cmd.rd && !known) |=> ($stable(mux_q) && $stable(tio_q) && $stable(lin_q)));

    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lin_q.hi == 4'h8 && lin_q.lo == 4'h0 && !mux_q.en && !tio_q && !lin_q.off));

endmodule

// File: rtl/tmux_route.sv
module tmux_route
    import tmux_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  mux_ctrl_t     ctrl,
    input  logic          tio_en,
    input  logic          dual,
    input  logic [DW-1:0] pa,
    input  logic [DW-1:0] pb,
    input  logic          dck,
    output logic          obs
);

    localparam int NADDR = 1 << PAIR_W;

    logic [DW:0]      b_ext;
    logic [NADDR-1:0] c_first, c_second, c_hit, c_is_a;

    assign b_ext = {dck, pb};

    for (genvar k = 0; k < NADDR; k++) begin : g_pair
        if (k >= 1 && k <= DW) begin : g_b
            assign c_first[k]  = b_ext[k-1];
            assign c_second[k] = b_ext[k];
            assign c_hit[k]    = 1'b1;
            assign c_is_a[k]   = 1'b0;
        end else if (k > DW && k <= 2*DW - 1) begin : g_a
            assign c_first[k]  = pa[k-DW-1];
            assign c_second[k] = pa[k-DW];
            assign c_hit[k]    = 1'b1;
            assign c_is_a[k]   = 1'b1;
        end else begin : g_none
            assign c_first[k]  = 1'b0;
            assign c_second[k] = 1'b0;
            assign c_hit[k]    = 1'b0;
            assign c_is_a[k]   = 1'b0;
        end
    end

    logic live, pick;
    assign live = ctrl.en && !tio_en && c_hit[ctrl.pair] && (dual || !c_is_a[ctrl.pair]);
    assign pick = ctrl.sel ? ~c_second[ctrl.pair] : c_first[ctrl.pair];
    assign obs  = live && pick;

    p_gate_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en || tio_en) |-> !obs);

    p_unused_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pair == '0) |-> !obs);

    p_single_a_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!dual && ctrl.pair > PAIR_W'(DW)) |-> !obs);

endmodule

// File: rtl/tmux_observe.sv
module tmux_observe
    import tmux_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_valid,
    input  logic [15:0]   cfg_word,
    output logic [7:0]    cfg_rdata,
    input  logic          dual_port,
    input  logic [DW-1:0] port_a,
    input  logic [DW-1:0] port_b,
    input  logic          dclk_in,
    output logic [3:0]    lin_gain,
    output logic          lin_off,
    output logic [3:0]    win_hi,
    output logic [3:0]    win_lo,
    output logic          tst_out
);

    cmd_t      cmd;
    mux_ctrl_t mux_q;
    lin_ctrl_t lin_q;
    logic      tio_q;

    assign cmd = cmd_t'(cfg_word);

    tmux_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd_vld (cfg_valid),
        .cmd     (cmd),
        .rdata   (cfg_rdata),
        .mux_q   (mux_q),
        .tio_q   (tio_q),
        .lin_q   (lin_q)
    );

    tmux_route #(.DW(DW)) u_route (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (mux_q),
        .tio_en (tio_q),
        .dual   (dual_port),
        .pa     (port_a),
        .pb     (port_b),
        .dck    (dclk_in),
        .obs    (tst_out)
    );

    assign lin_gain = lin_q.gain;
    assign lin_off  = lin_q.off;
    assign win_hi   = lin_q.hi;
    assign win_lo   = lin_q.lo;

endmodule

// File: tb/tb_tmux_observe.sv
module tb_tmux_observe;

    logic        clk = 0;
    logic        rst;
    logic        cfg_valid;
    logic [15:0] cfg_word;
    logic [7:0]  cfg_rdata;
    logic        dual_port;
    logic [15:0] port_a, port_b;
    logic        dclk_in;
    logic [3:0]  lin_gain, win_hi, win_lo;
    logic        lin_off, tst_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tmux_observe dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(bit rd, logic [6:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_valid = 1;
        cfg_word  = {rd, a, d};
        @(negedge clk);
        cfg_valid = 0;
        cfg_word  = '0;
    endtask

    task automatic rd_chk(string req, logic [6:0] a, logic [7:0] exp);
        cmd(1, a, 8'h00);
        chk(req, cfg_rdata, exp);
    endtask

    // Model of the observed output from the stated field layout (R3..R9)
    function automatic bit model(logic [7:0] m, bit tio, bit dual,
                                 logic [15:0] a, logic [15:0] b, bit dk);
        int  p = int'(m[5:1]);
        bit  f, s;
        logic [16:0] be = {dk, b};
        if (!m[6] || tio) return 0;
        if (p == 0) return 0;
        if (p <= 16) begin
            f = be[p-1]; s = be[p];
        end else begin
            if (!dual) return 0;
            f = a[p-17]; s = a[p-16];
        end
        return m[0] ? !s : f;
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] mreg;
        bit tio;
        void'($urandom(32'd1234));
        rst = 1; cfg_valid = 0; cfg_word = '0; dual_port = 1;
        port_a = '0; port_b = '0; dclk_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 tst_out", tst_out, 0);
        chk("R1 lin_gain", lin_gain, 0);
        chk("R1 lin_off", lin_off, 0);
        chk("R1 win_hi", win_hi, 4'h8);
        chk("R1 win_lo", win_lo, 0);
        rd_chk("R1 reg07", 7'h07, 8'h00);
        rd_chk("R1 reg08", 7'h08, 8'h80);
        rd_chk("R1 reg18", 7'h18, 8'h00);
        rd_chk("R1 reg19", 7'h19, 8'h00);

        // R11 / R2 linearization fields
        cmd(0, 7'h07, 8'hFB);
        chk("R11 lin_gain", lin_gain, 4'hB);
        chk("R11 lin_off", lin_off, 1);
        rd_chk("R11 reg07 readback", 7'h07, 8'h1B);
        cmd(0, 7'h08, 8'h3C);
        chk("R11 win_hi", win_hi, 4'h3);
        chk("R11 win_lo", win_lo, 4'hC);
        rd_chk("R2 reg08 readback", 7'h08, 8'h3C);
        // R2 read data holds with no new read
        @(negedge clk);
        chk("R2 rdata hold", cfg_rdata, 8'h3C);

        // R10 unimplemented addresses
        cmd(0, 7'h09, 8'hFF);
        cmd(0, 7'h1A, 8'hFF);
        rd_chk("R10 read 0x09", 7'h09, 8'h00);
        rd_chk("R10 read 0x7F", 7'h7F, 8'h00);
        rd_chk("R10 reg08 kept", 7'h08, 8'h3C);
        rd_chk("R10 reg19 kept", 7'h19, 8'h00);
        chk("R10 tst_out idle", tst_out, 0);

        // R3 / R6 directed: 0x60 -> B15 first, 0x61 -> clock inverted
        cmd(0, 7'h18, 8'hE0);
        rd_chk("R3 reg18 bit7 dropped", 7'h18, 8'h60);
        port_b = 16'h8000; dclk_in = 1; #1;
        chk("R4 R6 B15 first", tst_out, 1);
        port_b = 16'h0000; #1;
        chk("R4 R6 B15 low", tst_out, 0);
        cmd(0, 7'h18, 8'h61);
        dclk_in = 1; #1;
        chk("R5 R6 clock inverted hi", tst_out, 0);
        dclk_in = 0; #1;
        chk("R5 R6 clock inverted lo", tst_out, 1);

        // R8 test-I/O enable blocks output
        cmd(0, 7'h19, 8'hFF);
        rd_chk("R8 reg19 mask", 7'h19, 8'h01);
        chk("R8 gated by tio", tst_out, 0);
        cmd(0, 7'h19, 8'h00);
        chk("R8 released", tst_out, 1);

        // R9 pair address 0
        cmd(0, 7'h18, 8'h41);
        port_a = '1; port_b = '1; dclk_in = 0; #1;
        chk("R9 address 0 idle", tst_out, 0);

        // R7 port A in single-port mode
        cmd(0, 7'h18, {1'b0, 1'b1, 5'd20, 1'b0});
        port_a = 16'h0008; dual_port = 1; #1;
        chk("R7 dual A3 first", tst_out, 1);
        dual_port = 0; #1;
        chk("R7 single-port idle", tst_out, 0);
        dual_port = 1;

        // Random phase
        mreg = 8'h60; tio = 0;
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 4) == 0) begin
                mreg = 8'($urandom);
                cmd(0, 7'h18, mreg);
                mreg[7] = 0;
            end
            if (($urandom % 8) == 0) begin
                tio = bit'($urandom % 2);
                cmd(0, 7'h19, {7'($urandom), tio});
            end
            if (($urandom % 16) == 0) begin
                mreg = {1'b0, 1'b1, 5'd16 + 5'($urandom % 16), 1'($urandom)};
                cmd(0, 7'h18, mreg);
            end
            port_a = 16'($urandom); port_b = 16'($urandom);
            dclk_in = 1'($urandom); dual_port = 1'($urandom);
            #1;
            chk(mreg[0] ? "R5 R6 R7 R8 random inverted" : "R4 R6 R7 R8 random first",
                tst_out, model(mreg, tio, dual_port, port_a, port_b, dclk_in));
            @(negedge clk);
        end
        rd_chk("R3 random readback", 7'h18, mreg);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule